// File: doc/BRIEF.md
# Retired-Instruction Countdown Trigger Bank

This block holds a small bank of debug triggers, each of which counts down on retired instructions and signals when its count is used up. Software programs every trigger through a CSR-style port: an index picks one trigger, and a write replaces that trigger's whole configuration word. A read returns the word the index currently selects, in the same cycle.

The core raises `retire_valid` for one cycle for each instruction it retires. With that pulse it also gives the privilege level and whether the hart is running virtualized. A trigger that is armed loses one from its count. A trigger is armed when its count is not zero and the enable bit for the current mode is set. When the count steps from one to zero, the trigger raises its fire bit in that same cycle. The trigger's action code is shown on its own lane. What happens after a trigger fires is handled elsewhere.

A summary output tells the pipeline whether any trigger is armed in the current mode. The pipeline can use it to decide whether retirements have to be tracked one at a time.

Top module: `icnt_trig_bank`

## Requirements
- R1: The configuration word uses these fields:
  - bits 5:0 hold the action code;
  - bit 6 enables U mode;
  - bit 7 enables S mode;
  - bit 8 is a pending flag that is stored and has no other effect;
  - bit 9 enables M mode;
  - bits 23:10 hold the 14-bit count;
  - bit 24 is the hit flag;
  - bit 25 enables VU mode;
  - bit 26 enables VS mode.
  
  A read returns the stored 27-bit word. Bits 31:27 of `csr_rdata` always read as zero.
- R2: On a retire pulse, every armed trigger lowers its count by exactly one. A trigger is armed when its count is nonzero and its privilege condition matches.
- R3: When a retire pulse takes an armed trigger from count 1 to 0, its bit in `fire_mask` is high during that same cycle. Its 6-bit lane in `fire_action` (lane i at bits 6i+5:6i) then carries its action code. A lane reads zero when its trigger is not firing.
- R4: A trigger whose count is zero never decrements and never fires, whatever its enable bits are.
- R5: When `virt_mode` is 0, only the U, S and M enables are used. Privilege code 0 is U, 1 is S and 3 is M. Code 2 matches no trigger.
- R6: When `virt_mode` is 1, only the VU and VS enables are used. Privilege code 0 selects VU, code 1 selects VS, and codes 2 and 3 match nothing.
- R7: All triggers are evaluated on every retire pulse, and several of them may fire in the same cycle.
- R8: `armed_any` is high exactly when at least one trigger has a nonzero count and is enabled for the present `priv_lvl`/`virt_mode`. This holds whether or not a retire pulse is present.
- R9: A firing trigger sets its hit bit. The hit bit then stays set until a CSR write to that trigger replaces it.
- R10: When a CSR write and a decrement land on the same trigger in the same cycle, the written word is stored and the decrement is dropped.
- R11: After reset, every configuration word reads zero and no trigger is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe for the selected configuration word |
| csr_idx | input | 2 | Trigger select for read and write |
| csr_wdata | input | 27 | Configuration word to write |
| csr_rdata | output | 32 | Configuration word of the selected trigger, zero-extended |
| retire_valid | input | 1 | One-cycle pulse per retired instruction |
| priv_lvl | input | 2 | Current privilege code |
| virt_mode | input | 1 | Hart runs virtualized |
| fire_mask | output | 4 | Per-trigger fire pulse |
| fire_action | output | 24 | Per-trigger action code lanes, six bits each |
| armed_any | output | 1 | At least one trigger armed in the current mode |

## Verification
The assertions expect `priv_lvl` and `virt_mode` to describe the mode of the instruction that retires in the same cycle. They also expect a CSR write to be taken in the cycle its strobe is sampled. The stimulus changes inputs only between clock edges and holds them through each edge. It covers every privilege code in both virtualized and plain modes, including the unused code 2. Counts are kept small so that decrements reach zero often. Writes are placed in the same cycle as retirements to reach the overlap case.

// File: rtl/icnt_trig_pkg.sv
package icnt_trig_pkg;
  localparam int ACT_W    = 6;
  localparam int CNT_W    = 14;
  localparam int CFG_W    = 27;
  localparam int RD_W     = 32;
  localparam int ACT_LSB  = 0;
  localparam int EN_U     = 6;
  localparam int EN_S     = 7;
  localparam int PEND_BIT = 8;
  localparam int EN_M     = 9;
  localparam int CNT_LSB  = 10;
  localparam int HIT_BIT  = 24;
  localparam int EN_VU    = 25;
  localparam int EN_VS    = 26;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;
endpackage

// File: rtl/icnt_trig_priv_match.sv
module icnt_trig_priv_match
  import icnt_trig_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [1:0]       priv_i,
  input  logic             virt_i,
  output logic             match_o
);
  priv_e lvl;

  always_comb begin
    lvl = priv_e'(priv_i);
    match_o = 1'b0;
    if (virt_i) begin
      unique case (lvl)
        PRIV_USER:  match_o = cfg_i[EN_VU];
        PRIV_SUPER: match_o = cfg_i[EN_VS];
        default:    match_o = 1'b0;
      endcase
    end else begin
      unique case (lvl)
        PRIV_USER:  match_o = cfg_i[EN_U];
        PRIV_SUPER: match_o = cfg_i[EN_S];
        PRIV_MACH:  match_o = cfg_i[EN_M];
        default:    match_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/icnt_trig_slot.sv
module icnt_trig_slot
  import icnt_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             retire,
  input  logic [1:0]       priv,
  input  logic             virt,
  output logic [CFG_W-1:0] cfg_o,
  output logic             armed_o,
  output logic             fire_o,
  output logic [ACT_W-1:0] action_o
);
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             cfg_en;
  logic [CNT_W-1:0] cnt_q;
  logic             priv_ok;
  logic             step;

  assign cnt_q = cfg_q[CNT_LSB +: CNT_W];

  icnt_trig_priv_match u_match (
    .cfg_i   (cfg_q),
    .priv_i  (priv),
    .virt_i  (virt),
    .match_o (priv_ok)
  );

  assign armed_o  = (cnt_q != '0) && priv_ok;
  assign step     = retire && armed_o;
  assign fire_o   = step && (cnt_q == CNT_W'(1));
  assign action_o = fire_o ? cfg_q[ACT_LSB +: ACT_W] : '0;
  assign cfg_o    = cfg_q;

  // next state: software write has priority over the countdown
  always_comb begin
    cfg_d  = cfg_q;
    cfg_en = 1'b0;
    if (wr_en) begin
      cfg_d  = wr_data;
      cfg_en = 1'b1;
    end else if (step) begin
      cfg_d[CNT_LSB +: CNT_W] = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) cfg_d[HIT_BIT] = 1'b1;
      cfg_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  // R2: an eligible retire lowers the count by exactly one
  p_dec_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && armed_o && !wr_en) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R4: a zero count stays put without a write and never fires
  p_zero_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !wr_en) |=> (cnt_q == '0));
  p_zero_nofire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !fire_o);
  // R3: a fire leaves the count at zero unless a write replaced it
  p_fire_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !wr_en) |=> (cnt_q == '0 && cfg_q[HIT_BIT]));
  // R9: hit only clears through a write
  p_hit_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[HIT_BIT] && !wr_en) |=> cfg_q[HIT_BIT]);
  // R10: the written word is what gets stored
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q == $past(wr_data)));
endmodule

// File: rtl/icnt_trig_bank.sv
module icnt_trig_bank
  import icnt_trig_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      csr_we,
  input  logic [IDX_W-1:0]          csr_idx,
  input  logic [CFG_W-1:0]          csr_wdata,
  output logic [RD_W-1:0]           csr_rdata,
  input  logic                      retire_valid,
  input  logic [1:0]                priv_lvl,
  input  logic                      virt_mode,
  output logic [NUM_TRIG-1:0]       fire_mask,
  output logic [NUM_TRIG*ACT_W-1:0] fire_action,
  output logic                      armed_any
);
  logic [CFG_W-1:0]    cfg_arr [NUM_TRIG];
  logic [NUM_TRIG-1:0] armed_vec;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
    logic sel_we;
    assign sel_we = csr_we && (csr_idx == IDX_W'(g));
    icnt_trig_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (sel_we),
      .wr_data  (csr_wdata),
      .retire   (retire_valid),
      .priv     (priv_lvl),
      .virt     (virt_mode),
      .cfg_o    (cfg_arr[g]),
      .armed_o  (armed_vec[g]),
      .fire_o   (fire_mask[g]),
      .action_o (fire_action[g*ACT_W +: ACT_W])
    );
  end

  assign armed_any = |armed_vec;
  assign csr_rdata = {{(RD_W-CFG_W){1'b0}}, cfg_arr[csr_idx]};

  // R3: firing only happens with a retire pulse
  p_fire_on_retire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_mask != '0) |-> retire_valid);
  // R8: a fire implies the summary shows something armed
  p_fire_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_mask != '0) |-> armed_any);
endmodule

// File: tb/icnt_trig_bank_tb_top.sv
module icnt_trig_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_idx = '0;
  logic [26:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        retire_valid = 1'b0;
  logic [1:0]  priv_lvl = '0;
  logic        virt_mode = 1'b0;
  logic [3:0]  fire_mask;
  logic [23:0] fire_action;
  logic        armed_any;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string req = "R11";
  logic [26:0] m [4];

  always #5 clk = ~clk;

  icnt_trig_bank dut_i (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_idx(csr_idx),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .retire_valid(retire_valid),
    .priv_lvl(priv_lvl), .virt_mode(virt_mode), .fire_mask(fire_mask),
    .fire_action(fire_action), .armed_any(armed_any)
  );

  function automatic bit elig(int i);
    int c = int'(m[i][23:10]);
    bit ok;
    if (virt_mode) ok = (priv_lvl == 0 && m[i][25]) || (priv_lvl == 1 && m[i][26]);
    else ok = (priv_lvl == 0 && m[i][6]) || (priv_lvl == 1 && m[i][7]) ||
              (priv_lvl == 3 && m[i][9]);
    return (c != 0) && ok;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [3:0] em = '0;
    logic [23:0] ea = '0;
    bit arm = 0;
    for (int i = 0; i < 4; i++) begin
      if (elig(i)) arm = 1;
      if (retire_valid && elig(i) && m[i][23:10] == 14'd1) begin
        em[i] = 1'b1;
        ea[i*6 +: 6] = m[i][5:0];
      end
    end
    chk("fire_mask", 32'(fire_mask), 32'(em));
    chk("fire_action", 32'(fire_action), 32'(ea));
    chk("armed_any", 32'(armed_any), 32'(arm));
    chk("csr_rdata", csr_rdata, {5'b0, m[csr_idx]});
  endtask

  task automatic update();
    for (int i = 0; i < 4; i++) begin
      if (csr_we && csr_idx == 2'(i)) m[i] = csr_wdata;
      else if (retire_valid && elig(i)) begin
        if (m[i][23:10] == 14'd1) m[i][24] = 1'b1;
        m[i][23:10] = m[i][23:10] - 14'd1;
      end
    end
  endtask

  task automatic step(bit we, int idx, logic [26:0] wd, bit ret, int pv, bit vt);
    @(negedge clk);
    csr_we = we; csr_idx = 2'(idx); csr_wdata = wd;
    retire_valid = ret; priv_lvl = 2'(pv); virt_mode = vt;
    #1 compare();
    @(posedge clk);
    update();
  endtask

  function automatic logic [26:0] word(int act, int en, int cnt);
    return 27'(act) | 27'(en) | (27'(cnt) << 10);
  endfunction

  localparam int U = 1 << 6, S = 1 << 7, M = 1 << 9, VU = 1 << 25, VS = 1 << 26;

  initial begin
    for (int i = 0; i < 4; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    req = "R11";
    for (int i = 0; i < 4; i++) step(0, i, 0, 1, 3, 0);
    req = "R1";
    step(1, 0, 27'h7FF_FFFF, 0, 3, 0);
    step(0, 0, 0, 0, 3, 0);
    step(1, 0, 0, 0, 3, 0);
    req = "R2";
    step(1, 0, word(5, M, 3), 0, 3, 0);
    step(0, 0, 0, 1, 3, 0);
    step(0, 0, 0, 0, 3, 0);
    req = "R3";
    step(0, 0, 0, 1, 3, 0);
    step(0, 0, 0, 1, 3, 0);
    req = "R9";
    step(0, 0, 0, 1, 3, 0);
    step(0, 0, 0, 0, 0, 0);
    step(1, 0, word(5, 0, 0), 0, 0, 0);
    req = "R4";
    step(1, 1, word(9, U | S | M | VU | VS, 0), 1, 0, 0);
    step(0, 1, 0, 1, 3, 0);
    step(0, 1, 0, 1, 1, 1);
    req = "R5";
    step(1, 1, word(7, U, 4), 0, 0, 0);
    step(0, 1, 0, 1, 1, 0);
    step(0, 1, 0, 1, 2, 0);
    step(0, 1, 0, 1, 3, 0);
    step(0, 1, 0, 1, 0, 0);
    req = "R6";
    step(0, 1, 0, 1, 0, 1);
    step(1, 1, word(7, U | S | M | VS, 2), 0, 1, 1);
    step(0, 1, 0, 1, 0, 1);
    step(0, 1, 0, 1, 3, 1);
    step(0, 1, 0, 1, 1, 1);
    step(0, 1, 0, 1, 1, 1);
    req = "R7";
    step(1, 2, word(33, S, 2), 0, 1, 0);
    step(1, 3, word(62, S | VS, 2), 0, 1, 0);
    step(0, 2, 0, 1, 1, 0);
    step(0, 3, 0, 1, 1, 0);
    req = "R8";
    step(1, 2, word(1, U, 1), 0, 1, 0);
    step(0, 2, 0, 0, 0, 0);
    step(0, 2, 0, 0, 0, 1);
    req = "R10";
    step(1, 2, word(3, U, 8), 1, 0, 0);
    step(0, 2, 0, 0, 0, 0);
    step(1, 2, word(3, U, 1), 1, 0, 0);
    step(0, 2, 0, 0, 0, 0);
    req = "R7";
    for (int k = 0; k < 600; k++) begin
      bit we = ($urandom % 6) == 0;
      int act = int'($urandom % 64);
      int en = int'($urandom) & (U | S | M | VU | VS | (1 << 8));
      step(we, int'($urandom % 4), word(act, en, int'($urandom % 5)),
           ($urandom % 3) != 0, int'($urandom % 4), ($urandom % 4) == 0);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule